// File: doc/BRIEF.md
# Tagged Stack Execution Core

This block is a small stack-machine core that has no program store of its own. On every clock it presents the address of the instruction it wants and takes one instruction word back on the same cycle from an external supplier. It then executes that word against an operand stack of 16 entries, a small data RAM, a nonvolatile-style register array, a data input and output port and a random-value input. Each instruction word is 12 bits: bits [11:8] carry the opcode and bits [7:0] the immediate. Data words are 8 bits wide.

Every RAM cell, NVM cell and stack slot carries a privacy tag alongside its value. Moves between the stack and RAM or NVM carry the tag with the value. Arithmetic marks its result private when any operand was private. Data from the input port is always public and random data is always private. In the decode cycle of each instruction the core reports whether the word is one of the security-critical opcodes, and whether the operand on top of the stack is private. An outside verifier can use these two flags to decide whether to hold the `stall` input high until it is satisfied. While `stall` is high, nothing executes.

Top module: `xstack_core`

## Requirements
- R1: The program counter `pcReq` reads 1 after reset. Every instruction other than goto (0xD), if (0xE) and halt (0xF) advances it by one, modulo 256. Goto loads it with the immediate.
- R2: The if instruction (0xE) pops the top of the stack. A zero value moves `pcReq` to pc+1 and any other value moves it to the immediate.
- R3: While `stall` is high, no instruction executes and `pcReq`, the stack, the memories and the port outputs keep their values.
- R4: The transfer opcodes each use the low four bits of the immediate as the cell address and move the value together with its tag. Load (0x1) reads RAM and store (0x2) writes RAM. Getstatic (0x6) reads NVM and putstatic (0x7) writes NVM. Port load (0x3) pushes `ioIn` as public, random load (0x5) pushes `rngIn` as private, and push-zero (0x0) pushes a public zero.
- R5: Increment (0x8) and decrement (0x9) change the top by one, modulo 256. Xor (0xB) replaces the two top entries with their xor. Multiply (0xC) replaces them with the 16-bit product, leaving the low byte on top and the high byte beneath it. Each result is private if any input was private.
- R6: Port store (0x4) pops the top. From the edge that executes it, `ioOut` shows that value and `ioOutValid` is high for exactly one cycle.
- R7: While the core is not halted, `crit` is high in the decode cycle of a putstatic, port store or if word. In that cycle, `critPrivate` equals the tag of the top stack entry, or 0 when the stack is empty. When `crit` is low, `critPrivate` is low.
- R8: Reset clears every RAM tag. NVM values and tags persist across reset, and their power-up contents come from parameters.
- R9: Halt (0xF) sets `halted`. The core then freezes `pcReq` and executes nothing until reset.
- R10: A push onto a full stack (16 entries), or a word that needs more entries than the stack holds, does not execute. It sets `fault` and `halted`, and both stay set until reset.
- R11: Pop (0xA) discards the top entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pcReq | output | 8 | Address of the instruction requested this cycle |
| insWord | input | 12 | Instruction word for `pcReq`: opcode [11:8], immediate [7:0] |
| stall | input | 1 | Holds execution while high |
| ioIn | input | 8 | Data input port |
| rngIn | input | 8 | Random value source |
| ioOut | output | 8 | Data last emitted by a port store |
| ioOutValid | output | 1 | One-cycle pulse marking a new `ioOut` value |
| crit | output | 1 | Current word is security-critical |
| critPrivate | output | 1 | Tag of the top-of-stack operand for a critical word |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Stack overflow or underflow has occurred |

## Verification
A wrong stack pointer or a wrong stack value shows up at the ports within a few instructions. The instruction that depends on it sends `pcReq` the wrong way at an if, puts a wrong byte on `ioOut`, or raises `fault` early or late. A tag that is dropped or set where it should not be stays hidden until it reaches the top of the stack under a critical word. At that point `critPrivate` differs in that decode cycle. For this reason the stimulus routes tagged values through RAM, NVM, the ALU and a reset before sending them to a port store or an if. A reference model steps with the design and compares every output on every cycle, so any mismatch is caught in the cycle where it first appears.

// File: rtl/xsc_pkg.sv
package xsc_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [3:0] {
    OP_PUSH0 = 4'h0, OP_LOAD  = 4'h1, OP_STORE = 4'h2, OP_LDIO  = 4'h3,
    OP_STIO  = 4'h4, OP_LDRNG = 4'h5, OP_GETS  = 4'h6, OP_PUTS  = 4'h7,
    OP_INC   = 4'h8, OP_DEC   = 4'h9, OP_POP   = 4'hA, OP_XOR   = 4'hB,
    OP_MUL   = 4'hC, OP_GOTO  = 4'hD, OP_IF    = 4'hE, OP_HALT  = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    STK_NONE, STK_PUSH, STK_POP, STK_REPL, STK_FOLD, STK_PAIR
  } stkop_e;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_RAM, SRC_IO, SRC_RNG, SRC_NVM
  } pushsrc_e;

  typedef enum logic [1:0] {
    ALU_INC, ALU_DEC, ALU_XOR, ALU_MUL
  } aluop_e;

  typedef struct packed {
    stkop_e   stkOp;
    pushsrc_e pushSrc;
    aluop_e   aluOp;
    logic     ramWr;
    logic     nvmWr;
    logic     ioWr;
  } strobe_t;
endpackage

// File: rtl/xsc_dpath.sv
module xsc_dpath
  import xsc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STK_DEPTH = 16,
  parameter int RAM_DEPTH = 16,
  parameter int NVM_DEPTH = 16,
  parameter int ADDR_W = 4,
  parameter logic [NVM_DEPTH-1:0] NVM_PRIV_INIT = '0,
  parameter logic [NVM_DEPTH*DATA_W-1:0] NVM_DATA_INIT = '0,
  localparam int SP_W = $clog2(STK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] cellAddr,
  input  logic [DATA_W-1:0] ioIn,
  input  logic [DATA_W-1:0] rngIn,
  output logic [DATA_W-1:0] ioOut,
  output logic              ioOutValid,
  output logic [SP_W-1:0]   sp,
  output logic [DATA_W-1:0] topVal,
  output logic              topPriv
);
  localparam int IDX_W = $clog2(STK_DEPTH);
  localparam int RA_W  = $clog2(RAM_DEPTH);
  localparam int NA_W  = $clog2(NVM_DEPTH);

  logic [DATA_W-1:0]    stkVal [STK_DEPTH];
  logic [STK_DEPTH-1:0] stkPriv;
  logic [SP_W-1:0]      spQ;
  logic [IDX_W-1:0]     topIdx, nxtIdx, pushIdx;
  logic [DATA_W-1:0]    nxtVal;
  logic                 nxtPriv;

  logic [DATA_W-1:0]    ramVal [RAM_DEPTH];
  logic [RAM_DEPTH-1:0] ramPriv;
  logic [NVM_DEPTH*DATA_W-1:0] nvmFlat = NVM_DATA_INIT;
  logic [NVM_DEPTH-1:0]        nvmPriv = NVM_PRIV_INIT;

  logic [RA_W-1:0]      ramAddr;
  logic [NA_W-1:0]      nvmAddr;
  logic [DATA_W-1:0]    pushVal, aluLo, aluHi;
  logic                 pushPriv, aluPriv;
  logic [2*DATA_W-1:0]  prod;

  assign ramAddr = RA_W'(cellAddr);
  assign nvmAddr = NA_W'(cellAddr);
  assign topIdx  = IDX_W'(spQ - SP_W'(1));
  assign nxtIdx  = IDX_W'(spQ - SP_W'(2));
  assign pushIdx = IDX_W'(spQ);
  assign sp      = spQ;

  // entries beyond the live depth read as public zero
  always_comb begin
    topVal  = (spQ != '0) ? stkVal[topIdx] : '0;
    topPriv = (spQ != '0) && stkPriv[topIdx];
    nxtVal  = (spQ > SP_W'(1)) ? stkVal[nxtIdx] : '0;
    nxtPriv = (spQ > SP_W'(1)) && stkPriv[nxtIdx];
  end

  always_comb begin
    unique case (strb.pushSrc)
      SRC_RAM: begin pushVal = ramVal[ramAddr]; pushPriv = ramPriv[ramAddr]; end
      SRC_IO:  begin pushVal = ioIn;            pushPriv = 1'b0; end
      SRC_RNG: begin pushVal = rngIn;           pushPriv = 1'b1; end
      SRC_NVM: begin
        pushVal  = nvmFlat[nvmAddr*DATA_W +: DATA_W];
        pushPriv = nvmPriv[nvmAddr];
      end
      default: begin pushVal = '0; pushPriv = 1'b0; end
    endcase
  end

  assign prod = {{DATA_W{1'b0}}, topVal} * {{DATA_W{1'b0}}, nxtVal};

  always_comb begin
    aluHi = prod[2*DATA_W-1:DATA_W];
    unique case (strb.aluOp)
      ALU_INC: aluLo = topVal + DATA_W'(1);
      ALU_DEC: aluLo = topVal - DATA_W'(1);
      ALU_XOR: aluLo = topVal ^ nxtVal;
      default: aluLo = prod[DATA_W-1:0];
    endcase
    aluPriv = (strb.aluOp == ALU_INC || strb.aluOp == ALU_DEC) ?
              topPriv : (topPriv | nxtPriv);
  end

  // stack tags and depth: reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ     <= '0;
      stkPriv <= '0;
    end else begin
      unique case (strb.stkOp)
        STK_PUSH: begin stkPriv[pushIdx] <= pushPriv; spQ <= spQ + SP_W'(1); end
        STK_POP:  begin stkPriv[topIdx] <= 1'b0;      spQ <= spQ - SP_W'(1); end
        STK_REPL: stkPriv[topIdx] <= aluPriv;
        STK_FOLD: begin
          stkPriv[nxtIdx] <= aluPriv;
          stkPriv[topIdx] <= 1'b0;
          spQ <= spQ - SP_W'(1);
        end
        STK_PAIR: begin stkPriv[nxtIdx] <= aluPriv; stkPriv[topIdx] <= aluPriv; end
        default: ;
      endcase
    end
  end

  // stack values: no reset needed
  always_ff @(posedge clk) begin
    unique case (strb.stkOp)
      STK_PUSH: stkVal[pushIdx] <= pushVal;
      STK_REPL: stkVal[topIdx]  <= aluLo;
      STK_FOLD: stkVal[nxtIdx]  <= aluLo;
      STK_PAIR: begin stkVal[nxtIdx] <= aluHi; stkVal[topIdx] <= aluLo; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ramPriv <= '0;
    else if (strb.ramWr) ramPriv[ramAddr] <= topPriv;
  end

  always_ff @(posedge clk) begin
    if (strb.ramWr) ramVal[ramAddr] <= topVal;
  end

  // NVM keeps its contents through reset
  always_ff @(posedge clk) begin
    if (strb.nvmWr) begin
      nvmFlat[nvmAddr*DATA_W +: DATA_W] <= topVal;
      nvmPriv[nvmAddr] <= topPriv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioOut      <= '0;
      ioOutValid <= 1'b0;
    end else begin
      ioOutValid <= strb.ioWr;
      if (strb.ioWr) ioOut <= topVal;
    end
  end
endmodule

// File: rtl/xsc_ctrl.sv
module xsc_ctrl
  import xsc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W = 8,
  parameter int STK_DEPTH = 16,
  localparam int SP_W = $clog2(STK_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [OPC_W+IMM_W-1:0] insWord,
  input  logic                   stall,
  input  logic [SP_W-1:0]        sp,
  input  logic [DATA_W-1:0]      topVal,
  input  logic                   topPriv,
  output strobe_t                strb,
  output logic [IMM_W-1:0]       pcReq,
  output logic                   crit,
  output logic                   critPrivate,
  output logic                   halted,
  output logic                   fault
);
  opcode_e          opc;
  logic [IMM_W-1:0] imm, pcQ, pcNext;
  logic [1:0]       needN;
  logic             grows, stackErr, exec;
  strobe_t          raw;

  assign opc = opcode_e'(insWord[OPC_W+IMM_W-1:IMM_W]);
  assign imm = insWord[IMM_W-1:0];

  always_comb begin
    raw   = '{stkOp: STK_NONE, pushSrc: SRC_ZERO, aluOp: ALU_INC,
              ramWr: 1'b0, nvmWr: 1'b0, ioWr: 1'b0};
    needN = 2'd0;
    grows = 1'b0;
    unique case (opc)
      OP_PUSH0: begin raw.stkOp = STK_PUSH; grows = 1'b1; end
      OP_LOAD:  begin raw.stkOp = STK_PUSH; raw.pushSrc = SRC_RAM; grows = 1'b1; end
      OP_LDIO:  begin raw.stkOp = STK_PUSH; raw.pushSrc = SRC_IO;  grows = 1'b1; end
      OP_LDRNG: begin raw.stkOp = STK_PUSH; raw.pushSrc = SRC_RNG; grows = 1'b1; end
      OP_GETS:  begin raw.stkOp = STK_PUSH; raw.pushSrc = SRC_NVM; grows = 1'b1; end
      OP_STORE: begin raw.stkOp = STK_POP; raw.ramWr = 1'b1; needN = 2'd1; end
      OP_STIO:  begin raw.stkOp = STK_POP; raw.ioWr  = 1'b1; needN = 2'd1; end
      OP_PUTS:  begin raw.stkOp = STK_POP; raw.nvmWr = 1'b1; needN = 2'd1; end
      OP_POP, OP_IF: begin raw.stkOp = STK_POP; needN = 2'd1; end
      OP_INC:   begin raw.stkOp = STK_REPL; raw.aluOp = ALU_INC; needN = 2'd1; end
      OP_DEC:   begin raw.stkOp = STK_REPL; raw.aluOp = ALU_DEC; needN = 2'd1; end
      OP_XOR:   begin raw.stkOp = STK_FOLD; raw.aluOp = ALU_XOR; needN = 2'd2; end
      OP_MUL:   begin raw.stkOp = STK_PAIR; raw.aluOp = ALU_MUL; needN = 2'd2; end
      default: ;
    endcase
  end

  assign stackErr = (SP_W'(needN) > sp) || (grows && sp == SP_W'(STK_DEPTH));
  assign exec     = !stall && !halted && !stackErr;
  assign strb     = exec ? raw : '{stkOp: STK_NONE, pushSrc: SRC_ZERO,
                                   aluOp: ALU_INC, ramWr: 1'b0,
                                   nvmWr: 1'b0, ioWr: 1'b0};

  always_comb begin
    unique case (opc)
      OP_GOTO: pcNext = imm;
      OP_IF:   pcNext = (topVal != '0) ? imm : pcQ + IMM_W'(1);
      OP_HALT: pcNext = pcQ;
      default: pcNext = pcQ + IMM_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= IMM_W'(1);
      halted <= 1'b0;
      fault  <= 1'b0;
    end else if (!stall && !halted) begin
      if (stackErr) begin
        fault  <= 1'b1;
        halted <= 1'b1;
      end else begin
        pcQ <= pcNext;
        if (opc == OP_HALT) halted <= 1'b1;
      end
    end
  end

  assign pcReq       = pcQ;
  assign crit        = !halted && (opc == OP_PUTS || opc == OP_STIO || opc == OP_IF);
  assign critPrivate = crit && topPriv;
endmodule

// File: rtl/xstack_core.sv
module xstack_core
  import xsc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W = 8,
  parameter int STK_DEPTH = 16,
  parameter int RAM_DEPTH = 16,
  parameter int NVM_DEPTH = 16,
  parameter logic [NVM_DEPTH-1:0] NVM_PRIV_INIT = '0,
  parameter logic [NVM_DEPTH*DATA_W-1:0] NVM_DATA_INIT = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  output logic [IMM_W-1:0]       pcReq,
  input  logic [OPC_W+IMM_W-1:0] insWord,
  input  logic                   stall,
  input  logic [DATA_W-1:0]      ioIn,
  input  logic [DATA_W-1:0]      rngIn,
  output logic [DATA_W-1:0]      ioOut,
  output logic                   ioOutValid,
  output logic                   crit,
  output logic                   critPrivate,
  output logic                   halted,
  output logic                   fault
);
  localparam int SP_W   = $clog2(STK_DEPTH + 1);
  localparam int ADDR_W = ($clog2(RAM_DEPTH) > $clog2(NVM_DEPTH)) ?
                          $clog2(RAM_DEPTH) : $clog2(NVM_DEPTH);

  strobe_t           strb;
  logic [SP_W-1:0]   sp;
  logic [DATA_W-1:0] topVal;
  logic              topPriv;

  xsc_ctrl #(.DATA_W(DATA_W), .IMM_W(IMM_W), .STK_DEPTH(STK_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .insWord(insWord), .stall(stall), .sp(sp),
    .topVal(topVal), .topPriv(topPriv), .strb(strb), .pcReq(pcReq),
    .crit(crit), .critPrivate(critPrivate), .halted(halted), .fault(fault)
  );

  xsc_dpath #(
    .DATA_W(DATA_W), .STK_DEPTH(STK_DEPTH), .RAM_DEPTH(RAM_DEPTH),
    .NVM_DEPTH(NVM_DEPTH), .ADDR_W(ADDR_W), .NVM_PRIV_INIT(NVM_PRIV_INIT),
    .NVM_DATA_INIT(NVM_DATA_INIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cellAddr(ADDR_W'(insWord[IMM_W-1:0])),
    .ioIn(ioIn), .rngIn(rngIn), .ioOut(ioOut), .ioOutValid(ioOutValid),
    .sp(sp), .topVal(topVal), .topPriv(topPriv)
  );
endmodule

// File: rtl/xsc_checker.sv
module xsc_checker #(
  parameter int IMM_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [IMM_W-1:0] pcReq,
  input logic [IMM_W+3:0] insWord,
  input logic             stall,
  input logic             crit,
  input logic             critPrivate,
  input logic             halted,
  input logic             fault,
  input logic             ioOutValid
);
  logic [3:0] opc;
  assign opc = insWord[IMM_W+3:IMM_W];

  a_r1_pc_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> pcReq == IMM_W'(1));

  a_r1_goto_target: assert property (@(posedge clk) disable iff (!rstN)
    (opc == 4'hD && !stall && !halted) |=> pcReq == $past(insWord[IMM_W-1:0]));

  a_r3_stall_holds_pc: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(pcReq));

  a_r6_io_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    ioOutValid |-> $past(opc == 4'h4 && !stall && !halted));

  a_r7_private_needs_crit: assert property (@(posedge clk) disable iff (!rstN)
    critPrivate |-> crit);

  a_r7_no_crit_when_halted: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !crit);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && $stable(pcReq));

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

  a_r10_fault_halts: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> halted);
endmodule

bind xstack_core xsc_checker #(.IMM_W(IMM_W)) u_chk (
  .clk(clk), .rstN(rstN), .pcReq(pcReq), .insWord(insWord), .stall(stall),
  .crit(crit), .critPrivate(critPrivate), .halted(halted), .fault(fault),
  .ioOutValid(ioOutValid)
);

// File: tb/xstack_core_tb.sv
module xstack_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] insWord = 12'hF00;
  logic        stall = 1'b0;
  logic [7:0]  ioIn = 8'h00, rngIn = 8'h00;
  logic [7:0]  pcReq, ioOut;
  logic        ioOutValid, crit, critPrivate, halted, fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  xstack_core #(.NVM_PRIV_INIT(16'h0004)) u_dut (
    .clk(clk), .rstN(rstN), .pcReq(pcReq), .insWord(insWord), .stall(stall),
    .ioIn(ioIn), .rngIn(rngIn), .ioOut(ioOut), .ioOutValid(ioOutValid),
    .crit(crit), .critPrivate(critPrivate), .halted(halted), .fault(fault)
  );

  int nChecks = 0, nBad = 0;
  logic [11:0] prog [256];

  // behavioural reference state
  int mStkV[$];
  bit mStkP[$];
  int mRam[16];  bit mRamP[16];
  int mNvm[16];  bit mNvmP[16];
  int mPc;  bit mHalt, mFault, mIoV;  int mIoVal;
  int dutIo[$];
  int expQ[$];

  function automatic logic [11:0] mk(int op, int imm);
    logic [3:0] o = op[3:0];
    logic [7:0] i = imm[7:0];
    return {o, i};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 256; i++) prog[i] = 12'hF00;
  endtask

  task automatic modelReset();
    mPc = 1; mStkV = {}; mStkP = {};
    for (int i = 0; i < 16; i++) mRamP[i] = 1'b0;
    mHalt = 0; mFault = 0; mIoV = 0;
  endtask

  task automatic mPush(int v, bit p);
    mStkV.push_back(v & 255); mStkP.push_back(p);
  endtask

  task automatic modelStep(bit st);
    int op, imm, a, need, v1, v2, pr;
    bit p1, p2, grows;
    op = int'(insWord[11:8]); imm = int'(insWord[7:0]); a = imm & 15;
    mIoV = 0;
    if (st || mHalt) return;
    need = (op == 11 || op == 12) ? 2 :
           (op == 2 || op == 4 || op == 7 || op == 8 || op == 9 ||
            op == 10 || op == 14) ? 1 : 0;
    grows = (op == 0 || op == 1 || op == 3 || op == 5 || op == 6);
    if (mStkV.size() < need || (grows && mStkV.size() == 16)) begin
      mFault = 1; mHalt = 1; return;
    end
    case (op)
      0: mPush(0, 0);
      1: mPush(mRam[a], mRamP[a]);
      2: begin mRam[a] = mStkV.pop_back(); mRamP[a] = mStkP.pop_back(); end
      3: mPush(int'(ioIn), 0);
      4: begin mIoVal = mStkV.pop_back(); void'(mStkP.pop_back()); mIoV = 1; end
      5: mPush(int'(rngIn), 1);
      6: mPush(mNvm[a], mNvmP[a]);
      7: begin mNvm[a] = mStkV.pop_back(); mNvmP[a] = mStkP.pop_back(); end
      8: mStkV[mStkV.size()-1] = (mStkV[mStkV.size()-1] + 1) & 255;
      9: mStkV[mStkV.size()-1] = (mStkV[mStkV.size()-1] + 255) & 255;
      10: begin void'(mStkV.pop_back()); void'(mStkP.pop_back()); end
      11, 12: begin
        v1 = mStkV.pop_back(); p1 = mStkP.pop_back();
        v2 = mStkV.pop_back(); p2 = mStkP.pop_back();
        if (op == 11) mPush(v1 ^ v2, p1 | p2);
        else begin pr = v1 * v2; mPush(pr >> 8, p1 | p2); mPush(pr, p1 | p2); end
      end
      default: ;
    endcase
    if (op == 13) mPc = imm;
    else if (op == 14) begin
      v1 = mStkV.pop_back(); void'(mStkP.pop_back());
      mPc = (v1 != 0) ? imm : ((mPc + 1) & 255);
    end
    else if (op == 15) mHalt = 1;
    else mPc = (mPc + 1) & 255;
  endtask

  task automatic runProg(string req, int cycles, bit stallAlt);
    bit st, ec;
    @(negedge clk); rstN = 1'b0; modelReset(); dutIo = {};
    repeat (2) @(negedge clk);
    // R1: pc reads 1 right after reset
    check("R1", "pc after reset", int'(pcReq), 1);
    rstN = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      check(req, "pcReq (R1/R2)", int'(pcReq), mPc);
      check(req, "halted (R9)", int'(halted), int'(mHalt));
      check(req, "fault (R10)", int'(fault), int'(mFault));
      check(req, "ioOutValid (R6)", int'(ioOutValid), int'(mIoV));
      if (mIoV) check(req, "ioOut (R6)", int'(ioOut), mIoVal);
      if (ioOutValid) dutIo.push_back(int'(ioOut));
      st = stallAlt && (c % 2 == 1);
      stall = st;
      insWord = prog[mPc & 255];
      #1;
      ec = !mHalt && (insWord[11:8] == 4'h4 || insWord[11:8] == 4'h7 ||
                      insWord[11:8] == 4'hE);
      check(req, "crit (R7)", int'(crit), int'(ec));
      check(req, "critPrivate (R7)", int'(critPrivate),
            int'(ec && mStkP.size() > 0 && mStkP[mStkP.size()-1]));
      modelStep(st);
      @(negedge clk);
    end
    stall = 1'b0;
  endtask

  task automatic expectIo(string req);
    check(req, "port output count", dutIo.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < dutIo.size(); i++)
      check(req, "port output value", dutIo[i], expQ[i]);
  endtask

  task automatic loadBasic();
    clearProg();
    prog[1] = mk(3, 0);  prog[2] = mk(2, 2);  prog[3] = mk(0, 0);
    prog[4] = mk(8, 0);  prog[5] = mk(8, 0);  prog[6] = mk(0, 0);
    prog[7] = mk(10, 0); prog[8] = mk(1, 2);  prog[9] = mk(4, 0);
    prog[10] = mk(13, 20); prog[20] = mk(4, 0); prog[21] = mk(15, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mNvm[i] = 0; mNvmP[i] = (i == 2); mRam[i] = 0;
    end
    modelReset();

    // R1 R4 R6 R11: port load, RAM transfer, inc, pop, goto
    loadBasic(); ioIn = 8'h5A;
    runProg("R4", 20, 1'b0);
    expQ = '{'h5A, 'h02}; expectIo("R11");

    // R3: same program with every other cycle stalled
    runProg("R3", 40, 1'b1);
    expQ = '{'h5A, 'h02}; expectIo("R3");

    // R2 R5 R7: mul order, if both ways, dec wrap, xor taint, preset NVM tag
    clearProg(); ioIn = 8'h13; rngIn = 8'h0F;
    prog[1] = mk(3, 0);  prog[2] = mk(3, 0);  prog[3] = mk(12, 0);
    prog[4] = mk(4, 0);  prog[5] = mk(4, 0);  prog[6] = mk(0, 0);
    prog[7] = mk(14, 30); prog[8] = mk(0, 0); prog[9] = mk(8, 0);
    prog[10] = mk(14, 40);
    prog[40] = mk(0, 0);  prog[41] = mk(9, 0); prog[42] = mk(5, 0);
    prog[43] = mk(11, 0); prog[44] = mk(4, 0); prog[45] = mk(6, 2);
    prog[46] = mk(14, 50); prog[47] = mk(15, 0);
    runProg("R5", 25, 1'b0);
    expQ = '{'h69, 'h01, 'hF0}; expectIo("R5");
    check("R2", "final pc after zero if", int'(pcReq), 47);

    // R8: NVM write survives reset, RAM tag cleared by reset
    clearProg(); ioIn = 8'h77; rngIn = 8'h0F;
    prog[1] = mk(3, 0); prog[2] = mk(7, 5); prog[3] = mk(5, 0);
    prog[4] = mk(2, 3); prog[5] = mk(15, 0);
    runProg("R8", 8, 1'b0);
    clearProg(); ioIn = 8'h00;
    prog[1] = mk(6, 5); prog[2] = mk(4, 0); prog[3] = mk(1, 3);
    prog[4] = mk(4, 0); prog[5] = mk(15, 0);
    runProg("R8", 10, 1'b0);
    expQ = '{'h77, 'h0F}; expectIo("R8");

    // R10: underflow
    clearProg(); prog[1] = mk(10, 0);
    runProg("R10", 6, 1'b0);
    check("R10", "underflow fault", int'(fault), 1);
    check("R10", "underflow pc held", int'(pcReq), 1);

    // R10: overflow on the seventeenth push
    clearProg();
    for (int i = 1; i <= 17; i++) prog[i] = mk(0, 0);
    runProg("R10", 22, 1'b0);
    check("R10", "overflow fault", int'(fault), 1);
    check("R10", "overflow pc held", int'(pcReq), 17);

    // R9: halt freezes the core
    clearProg(); prog[1] = mk(0, 0); prog[2] = mk(15, 0);
    runProg("R9", 8, 1'b0);
    check("R9", "halted after halt", int'(halted), 1);
    check("R9", "pc frozen at halt", int'(pcReq), 2);

    summary();
    $finish;
  end
endmodule